// File: doc/BRIEF.md
# SMI Status Aggregation Register

This block holds the 32-bit status word that tells system-management firmware why the system-management interrupt was raised. Five causes are captured as sticky bits from single-cycle event pulses. These are a microcontroller-range I/O access, expiry of the software SMI timer, a write to the power-management control port, a write of one to the sleep-enable control, and a global-release request. Software clears each of these bits by writing one to it.

Four more causes come from level-status vectors that live elsewhere: general-purpose inputs, GPE0, PM1 and legacy USB keyboard/mouse. Each is paired with an enable vector. For each of these the block reports one read-only summary bit, computed live from its inputs.

A simple register bus reads the word combinationally and clears the sticky bits. The active-low `smi_n` output is asserted while any bit that is allowed to request an interrupt is set.

Top module: `smi_status_agg`

## Requirements
- R1: After a synchronous reset the word reads 00000000h and `smi_n` is high, provided all inputs are idle.
- R2: Bit 11 (microcontroller access) sets on an `ev_mc_access` pulse and clears on a write of 1 to bit 11. It pulls `smi_n` low only while `mc_smi_en` is 1.
- R3: Bit 6 (software timer) sets on an `ev_swsmi_expire` pulse and clears on a write of 1 to bit 6.
- R4: Bit 5 (control-port write) sets on an `ev_apm_write` pulse only while `apm_en` is 1, and clears on a write of 1 to bit 5.
- R5: Bit 4 (sleep request) sets on an `ev_slp_write1` pulse only while `slp_smi_en` is 1, and clears on a write of 1 to bit 4.
- R6: Bit 2 (global release) sets on an `ev_gbl_rls` pulse only while `bios_en` is 1, and clears on a write of 1 to bit 2.
- R7: Bit 10 is the OR over all positions of `gpi_sts & gpi_route & gpi_en`. A status bit that is not routed has no effect on it.
- R8: Bit 9 is the OR over all positions of `gpe0_sts & gpe0_en`.
- R9: Bit 8 is the OR over all positions of `pm1_sts & pm1_en`.
- R10: Bit 3 is the OR over all positions of `usb_sts & usb_en`. It reads 0 whenever `usb_en` is all zero.
- R11: Bits 1:0, bit 7 and bits 31:12 always read 0. Writes to them, and writes to the summary bits 3 and 8 to 10, change nothing.
- R12: When a set pulse and a write-1 clear hit the same sticky bit in the same cycle, the bit ends up set.
- R13: `smi_n` is low exactly when at least one of these holds:
  - bit 2, 4, 5 or 6 is set;
  - bit 11 is set while `mc_smi_en` is 1;
  - any of the summary bits 3, 8, 9 or 10 is 1.
- R14: `reg_rdata` shows the word when `reg_addr` equals the register offset (default 34h), and reads 0 at any other address. Writes to other addresses clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_mc_access | input | 1 | Pulse: I/O access to the microcontroller range |
| mc_smi_en | input | 1 | Lets bit 11 request an interrupt |
| ev_swsmi_expire | input | 1 | Pulse: software SMI timer expired |
| ev_apm_write | input | 1 | Pulse: write to the power-management control port |
| apm_en | input | 1 | Qualifies capture of bit 5 |
| ev_slp_write1 | input | 1 | Pulse: one written to the sleep-enable control |
| slp_smi_en | input | 1 | Qualifies capture of bit 4 |
| ev_gbl_rls | input | 1 | Pulse: global-release request written |
| bios_en | input | 1 | Qualifies capture of bit 2 |
| gpi_sts | input | GPI_W | General-purpose input status |
| gpi_route | input | GPI_W | Per-input routing to SMI |
| gpi_en | input | GPI_W | Per-input SMI enable |
| gpe0_sts | input | GPE_W | GPE0 status |
| gpe0_en | input | GPE_W | GPE0 enable |
| pm1_sts | input | PM1_W | PM1 status |
| pm1_en | input | PM1_W | PM1 SMI enable |
| usb_sts | input | USB_W | Legacy USB keyboard/mouse SMI status |
| usb_en | input | USB_W | Legacy USB SMI enable |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; a one clears the matching sticky bit |
| reg_rdata | output | 32 | Combinational read data |
| smi_n | output | 1 | Active-low system-management interrupt request |

## Verification
The hardest case to reach is the collision: a set pulse and a write-1 clear on the same bit in the same cycle. A second hard case is a status bit that is set but whose interrupt path is closed, either the microcontroller bit with its enable low or a general-purpose input that is not routed. Directed steps produce the collision on the timer bit, and also show both masking cases through `reg_rdata` and `smi_n`. A long random phase then drives rare event pulses, random write-1 patterns that hit both reserved and live bits, and occasional reads at a wrong address. A behavioural model compares every field against the ports on every cycle.

// File: rtl/smi_pkg.sv
// Package: bit map and sticky-source indices shared by the SMI status block.
// Assumes a 32-bit register word.
package smi_pkg;

    localparam int REG_W = 32;

    localparam int POS_BIOS  = 2;
    localparam int POS_USB   = 3;
    localparam int POS_SLP   = 4;
    localparam int POS_APM   = 5;
    localparam int POS_SWTMR = 6;
    localparam int POS_PM1   = 8;
    localparam int POS_GPE0  = 9;
    localparam int POS_GPI   = 10;
    localparam int POS_MC    = 11;

    typedef enum int {
        STK_BIOS  = 0,
        STK_SLP   = 1,
        STK_APM   = 2,
        STK_SWTMR = 3,
        STK_MC    = 4
    } sticky_idx_e;

    localparam int NUM_STICKY = 5;
    localparam int NUM_SUMMARY = 4;

    // Maps a sticky-source index to its bit position in the word.
    function automatic int sticky_pos(input int idx);
        case (idx)
            STK_BIOS:  return POS_BIOS;
            STK_SLP:   return POS_SLP;
            STK_APM:   return POS_APM;
            STK_SWTMR: return POS_SWTMR;
            default:   return POS_MC;
        endcase
    endfunction

    // Maps a summary index (0 usb, 1 pm1, 2 gpe0, 3 gpi) to its bit position.
    function automatic int summary_pos(input int idx);
        case (idx)
            0:       return POS_USB;
            1:       return POS_PM1;
            2:       return POS_GPE0;
            default: return POS_GPI;
        endcase
    endfunction

endpackage

// File: rtl/smi_sticky_bits.sv
// Module: bank of sticky status flags.
// Each flag sets on its qualified pulse and clears on its clear strobe.
// Set has priority over clear in the same cycle.
// Assumes the set and clear inputs are synchronous to clk.
module smi_sticky_bits #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_q
);

    // Capture events and apply write-1-to-clear, set winning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= set_i | (flag_q & ~clr_i);
        end
    end

endmodule

// File: rtl/smi_summary.sv
// Module: live summary of a status vector gated by its enable vector.
// The output is the OR of the bitwise AND of the two vectors.
// Purely combinational; no state.
module smi_summary #(
    parameter int W = 8
) (
    input  logic [W-1:0] sts_i,
    input  logic [W-1:0] en_i,
    output logic         hit_o
);

    // Reduce the enabled status bits to one flag.
    always_comb begin
        hit_o = |(sts_i & en_i);
    end

endmodule

// File: rtl/smi_irq_combine.sv
// Module: forms the active-low SMI request from the sticky flags and the summaries.
// The microcontroller flag counts only with its own enable.
// Every other sticky flag, and every summary, counts unconditionally.
module smi_irq_combine
    import smi_pkg::*;
(
    input  logic [NUM_STICKY-1:0]  flag_i,
    input  logic                   mc_en_i,
    input  logic [NUM_SUMMARY-1:0] summ_i,
    output logic                   smi_n_o
);

    logic [NUM_STICKY-1:0] elig;

    // Per-flag eligibility; only the microcontroller flag has a gate.
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_elig
        if (i == STK_MC) begin : g_gated
            assign elig[i] = flag_i[i] & mc_en_i;
        end else begin : g_open
            assign elig[i] = flag_i[i];
        end
    end

    // Combine all eligible causes into the active-low request.
    always_comb begin
        smi_n_o = ~((|elig) | (|summ_i));
    end

endmodule

// File: rtl/smi_status_agg.sv
// Module: SMI status register.
// Holds five sticky causes and four live summary causes.
// Reads are combinational, with a write-1-to-clear port.
// Drives the active-low SMI request.
// Assumes event pulses last one clock and bus signals are synchronous.
module smi_status_agg
    import smi_pkg::*;
#(
    parameter int          GPI_W      = 16,
    parameter int          GPE_W      = 16,
    parameter int          PM1_W      = 8,
    parameter int          USB_W      = 8,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  REG_OFFSET = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_mc_access,
    input  logic              mc_smi_en,
    input  logic              ev_swsmi_expire,
    input  logic              ev_apm_write,
    input  logic              apm_en,
    input  logic              ev_slp_write1,
    input  logic              slp_smi_en,
    input  logic              ev_gbl_rls,
    input  logic              bios_en,
    input  logic [GPI_W-1:0]  gpi_sts,
    input  logic [GPI_W-1:0]  gpi_route,
    input  logic [GPI_W-1:0]  gpi_en,
    input  logic [GPE_W-1:0]  gpe0_sts,
    input  logic [GPE_W-1:0]  gpe0_en,
    input  logic [PM1_W-1:0]  pm1_sts,
    input  logic [PM1_W-1:0]  pm1_en,
    input  logic [USB_W-1:0]  usb_sts,
    input  logic [USB_W-1:0]  usb_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              smi_n
);

    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);

    logic                   addr_hit;
    logic                   wr_hit;
    logic [NUM_STICKY-1:0]  set_v;
    logic [NUM_STICKY-1:0]  clr_v;
    logic [NUM_STICKY-1:0]  flag_q;
    logic [NUM_SUMMARY-1:0] summ;
    logic [GPI_W-1:0]       gpi_gate;
    logic [REG_W-1:0]       word;

    // Decode the register address and the write strobe.
    always_comb begin
        addr_hit = (reg_addr == OFF);
        wr_hit   = reg_wr & addr_hit;
    end

    // Qualify each event pulse with its capture enable.
    always_comb begin
        set_v            = '0;
        set_v[STK_BIOS]  = ev_gbl_rls & bios_en;
        set_v[STK_SLP]   = ev_slp_write1 & slp_smi_en;
        set_v[STK_APM]   = ev_apm_write & apm_en;
        set_v[STK_SWTMR] = ev_swsmi_expire;
        set_v[STK_MC]    = ev_mc_access;
    end

    // Route each write-data bit to the sticky flag it clears.
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_clr
        assign clr_v[i] = wr_hit & reg_wdata[sticky_pos(i)];
    end

    smi_sticky_bits #(.N(NUM_STICKY)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .flag_q (flag_q)
    );

    // A general-purpose input counts only when routed and enabled.
    always_comb begin
        gpi_gate = gpi_route & gpi_en;
    end

    smi_summary #(.W(USB_W)) u_sum_usb (
        .sts_i (usb_sts),
        .en_i  (usb_en),
        .hit_o (summ[0])
    );

    smi_summary #(.W(PM1_W)) u_sum_pm1 (
        .sts_i (pm1_sts),
        .en_i  (pm1_en),
        .hit_o (summ[1])
    );

    smi_summary #(.W(GPE_W)) u_sum_gpe0 (
        .sts_i (gpe0_sts),
        .en_i  (gpe0_en),
        .hit_o (summ[2])
    );

    smi_summary #(.W(GPI_W)) u_sum_gpi (
        .sts_i (gpi_sts),
        .en_i  (gpi_gate),
        .hit_o (summ[3])
    );

    // Assemble the readable word; unlisted positions stay zero.
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_STICKY; i++) begin
            word[sticky_pos(i)] = flag_q[i];
        end
        for (int j = 0; j < NUM_SUMMARY; j++) begin
            word[summary_pos(j)] = summ[j];
        end
    end

    // Present the word only when the register is addressed.
    always_comb begin
        reg_rdata = addr_hit ? word : '0;
    end

    smi_irq_combine u_irq (
        .flag_i  (flag_q),
        .mc_en_i (mc_smi_en),
        .summ_i  (summ),
        .smi_n_o (smi_n)
    );

endmodule

// File: rtl/smi_status_agg_chk.sv
// Checker: temporal properties of the SMI status register.
// Attached to the top module by bind; observes ports and the sticky flags.
module smi_status_agg_chk
    import smi_pkg::*;
#(
    parameter int          USB_W      = 8,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  REG_OFFSET = 8'h34
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ev_mc_access,
    input logic                  ev_swsmi_expire,
    input logic                  ev_apm_write,
    input logic                  apm_en,
    input logic [USB_W-1:0]      usb_en,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_wr,
    input logic [REG_W-1:0]      reg_wdata,
    input logic [REG_W-1:0]      reg_rdata,
    input logic                  smi_n,
    input logic [NUM_STICKY-1:0] flag_q
);

    logic at_reg;
    logic clr_tmr;
    assign at_reg  = (reg_addr == ADDR_W'(REG_OFFSET));
    assign clr_tmr = reg_wr && at_reg && reg_wdata[POS_SWTMR];

    p_mc_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mc_access |=> flag_q[STK_MC]);

    p_tmr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tmr && !ev_swsmi_expire) |=> !flag_q[STK_SWTMR]);

    p_apm_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[STK_APM] && !(ev_apm_write && apm_en)) |=> !flag_q[STK_APM]);

    p_usb_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (at_reg && usb_en == '0) |-> !reg_rdata[POS_USB]);

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        at_reg |-> (reg_rdata[1:0] == 2'b00 && !reg_rdata[7] && reg_rdata[31:12] == '0));

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tmr && ev_swsmi_expire) |=> flag_q[STK_SWTMR]);

    p_tmr_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[STK_SWTMR] |-> !smi_n);

    p_miss_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !at_reg |-> (reg_rdata == '0));

endmodule

bind smi_status_agg smi_status_agg_chk #(
    .USB_W      (USB_W),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ev_mc_access    (ev_mc_access),
    .ev_swsmi_expire (ev_swsmi_expire),
    .ev_apm_write    (ev_apm_write),
    .apm_en          (apm_en),
    .usb_en          (usb_en),
    .reg_addr        (reg_addr),
    .reg_wr          (reg_wr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .smi_n           (smi_n),
    .flag_q          (flag_q)
);

// File: tb/smi_status_agg_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared field by field on every clock.
module smi_status_agg_test;

    localparam int GW = 16, EW = 16, PW = 8, UW = 8;

    logic clk = 0, rst_n = 0;
    logic ev_mc = 0, mc_en = 0, ev_tmr = 0, ev_apm = 0, apm_en = 0;
    logic ev_slp = 0, slp_en = 0, ev_gbl = 0, bios_en = 0;
    logic [GW-1:0] gpi_sts = '0, gpi_route = '0, gpi_en = '0;
    logic [EW-1:0] gpe_sts = '0, gpe_en = '0;
    logic [PW-1:0] pm1_sts = '0, pm1_en = '0;
    logic [UW-1:0] usb_sts = '0, usb_en = '0;
    logic [7:0]  addr = 8'h34;
    logic        wr = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        smi_n;

    int checks = 0, errors = 0;
    bit done = 0, live = 0;
    bit m_bios, m_slp, m_apm, m_tmr, m_mc;

    always #4 clk = ~clk;

    smi_status_agg uut (
        .clk(clk), .rst_n(rst_n),
        .ev_mc_access(ev_mc), .mc_smi_en(mc_en), .ev_swsmi_expire(ev_tmr),
        .ev_apm_write(ev_apm), .apm_en(apm_en), .ev_slp_write1(ev_slp),
        .slp_smi_en(slp_en), .ev_gbl_rls(ev_gbl), .bios_en(bios_en),
        .gpi_sts(gpi_sts), .gpi_route(gpi_route), .gpi_en(gpi_en),
        .gpe0_sts(gpe_sts), .gpe0_en(gpe_en), .pm1_sts(pm1_sts), .pm1_en(pm1_en),
        .usb_sts(usb_sts), .usb_en(usb_en), .reg_addr(addr), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rdata(rdata), .smi_n(smi_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: next state from current inputs at each rising edge.
    always @(posedge clk) begin
        bit hit;
        hit = wr && addr == 8'h34;
        if (!rst_n) begin
            m_bios = 0; m_slp = 0; m_apm = 0; m_tmr = 0; m_mc = 0;
        end else begin
            m_bios = (ev_gbl && bios_en) ? 1 : (hit && wdata[2])  ? 0 : m_bios;
            m_slp  = (ev_slp && slp_en)  ? 1 : (hit && wdata[4])  ? 0 : m_slp;
            m_apm  = (ev_apm && apm_en)  ? 1 : (hit && wdata[5])  ? 0 : m_apm;
            m_tmr  = ev_tmr              ? 1 : (hit && wdata[6])  ? 0 : m_tmr;
            m_mc   = ev_mc               ? 1 : (hit && wdata[11]) ? 0 : m_mc;
        end
    end

    // Compare every field mid-cycle, away from the edge.
    always @(negedge clk) begin
        bit s_gpi, s_gpe, s_pm1, s_usb, exp_irq;
        if (live && !done) begin
            s_gpi = |(gpi_sts & gpi_route & gpi_en);
            s_gpe = |(gpe_sts & gpe_en);
            s_pm1 = |(pm1_sts & pm1_en);
            s_usb = |(usb_sts & usb_en);
            exp_irq = m_bios | m_slp | m_apm | m_tmr | (m_mc & mc_en) | s_gpi | s_gpe | s_pm1 | s_usb;
            chk("R13 smi_n", {31'd0, smi_n}, {31'd0, ~exp_irq});
            if (addr == 8'h34) begin
                chk("R2 mc bit11", {31'd0, rdata[11]}, {31'd0, m_mc});
                chk("R3 timer bit6", {31'd0, rdata[6]}, {31'd0, m_tmr});
                chk("R4 apm bit5", {31'd0, rdata[5]}, {31'd0, m_apm});
                chk("R5 sleep bit4", {31'd0, rdata[4]}, {31'd0, m_slp});
                chk("R6 bios bit2", {31'd0, rdata[2]}, {31'd0, m_bios});
                chk("R7 gpi bit10", {31'd0, rdata[10]}, {31'd0, s_gpi});
                chk("R8 gpe0 bit9", {31'd0, rdata[9]}, {31'd0, s_gpe});
                chk("R9 pm1 bit8", {31'd0, rdata[8]}, {31'd0, s_pm1});
                chk("R10 usb bit3", {31'd0, rdata[3]}, {31'd0, s_usb});
                chk("R11 reserved", rdata & 32'hFFFF_F083, 32'd0);
            end else begin
                chk("R14 other address", rdata, 32'd0);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic idle();
        ev_mc = 0; ev_tmr = 0; ev_apm = 0; ev_slp = 0; ev_gbl = 0; wr = 0; wdata = '0;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1; live = 1;
        cyc();
        @(negedge clk);
        chk("R1 reset word", rdata, 32'd0);
        chk("R1 reset smi_n", {31'd0, smi_n}, 32'd1);
        cyc();
        // R12: timer pulse and clear on the same edge; set must win.
        ev_tmr = 1; wr = 1; wdata = 32'h40; cyc(); idle();
        @(negedge clk);
        chk("R12 set wins", {31'd0, rdata[6]}, 32'd1);
        cyc();
        wr = 1; wdata = 32'h40; cyc(); idle();
        @(negedge clk);
        chk("R3 cleared", {31'd0, rdata[6]}, 32'd0);
        cyc();
        // R2: mc bit set with enable off must leave smi_n high.
        ev_mc = 1; cyc(); idle();
        @(negedge clk);
        chk("R2 mc set, masked", {rdata[11], 30'd0, smi_n}, {1'b1, 30'd0, 1'b1});
        cyc();
        mc_en = 1; cyc();
        @(negedge clk);
        chk("R2 mc enabled", {31'd0, smi_n}, 32'd0);
        cyc();
        wr = 1; wdata = 32'h800; cyc(); idle(); mc_en = 0;
        // R7: unrouted input has no effect.
        gpi_sts = 16'h0004; gpi_en = 16'h0004; gpi_route = 16'h0000; cyc();
        @(negedge clk);
        chk("R7 unrouted", {rdata[10], 30'd0, smi_n}, {1'b0, 30'd0, 1'b1});
        cyc();
        gpi_route = 16'h0004; cyc();
        @(negedge clk);
        chk("R7 routed", {31'd0, rdata[10]}, 32'd1);
        cyc();
        // R11: writing summary and reserved positions changes nothing.
        wr = 1; wdata = 32'hFFFF_F7BB; cyc(); idle();
        @(negedge clk);
        chk("R11 summary kept", {31'd0, rdata[10]}, 32'd1);
        cyc();
        gpi_sts = '0;
        // R4: gated capture.
        ev_apm = 1; apm_en = 0; cyc(); idle();
        @(negedge clk);
        chk("R4 gated off", {31'd0, rdata[5]}, 32'd0);
        cyc();
        // Random phase.
        for (int n = 0; n < 20000; n++) begin
            ev_mc  = ($urandom % 10) == 0;
            ev_tmr = ($urandom % 10) == 0;
            ev_apm = ($urandom % 8) == 0;
            ev_slp = ($urandom % 8) == 0;
            ev_gbl = ($urandom % 8) == 0;
            mc_en  = $urandom; apm_en = $urandom; slp_en = $urandom; bios_en = $urandom;
            gpi_sts = ($urandom % 4 == 0) ? 16'($urandom) : '0;
            gpi_route = 16'($urandom); gpi_en = 16'($urandom);
            gpe_sts = ($urandom % 4 == 0) ? 16'($urandom) : '0; gpe_en = 16'($urandom);
            pm1_sts = ($urandom % 4 == 0) ? 8'($urandom) : '0; pm1_en = 8'($urandom);
            usb_sts = 8'($urandom); usb_en = ($urandom % 3 == 0) ? '0 : 8'($urandom);
            wr = ($urandom % 4) == 0;
            wdata = $urandom;
            addr = ($urandom % 8 == 0) ? 8'h30 : 8'h34;
            cyc();
        end
        idle(); addr = 8'h34;
        cyc(); cyc();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule